// File: doc/BRIEF.md
# Asynchronous Timer Register Update Bridge

This block places an 8-bit timer/counter behind a host register port. The host port runs on the system clock. The timer can run from that same clock or from a separate oscillator input. The timer owns three registers: a live count, a compare value and a rate control.

Every host write to one of these registers first lands in a staging register on the host side. In synchronous mode the staged value is loaded into the timer at the same clock edge as the write. In asynchronous mode the load crosses into the oscillator domain through a toggle request/acknowledge handshake. While that transfer is in flight, a per-register busy bit reads as one. The busy bit clears by hardware once the acknowledge has returned to the host side.

A status word holds three things: the clock-source select, an external-clock enable, and the three busy bits. A global word holds two things: a prescaler-reset request and a hold mode that keeps the prescaler in reset. A compare match is returned to the host clock domain as a one-cycle interrupt pulse.

Top module: `async_timer_bridge`

## Requirements
- R1: After reset, every readable word (addresses 0 to 4) reads zero and `xtalEn` is 1.
- R2: With the clock select at 0, a write to address 0 (count), 1 (compare) or 2 (control) is in effect from the clock edge that accepts it. In this mode all three busy bits stay at 0.
- R3: With the clock select at 1, a write sets the busy bit of the written register at the next host edge. The busy bits sit in the status word as follows: bit 2 is count, bit 1 is compare, bit 0 is control.
- R4: In asynchronous mode each busy bit returns to 0 without further host action. Once it is 0, the written value is in effect in the timer.
- R5: Reading address 0 returns the running count. Reading address 1 or 2 returns the last value written to that address.
- R6: The status word (address 3) has the external-clock enable at bit 4 and the clock select at bit 3; both are writable. Writing ones to bits 2:0 has no effect. `xtalEn` is the inverse of the external-clock enable.
- R7: Control bits 1:0 set the counting rate: 0 stops the counter, 1 counts every timer clock, 2 counts every 4th clock, 3 counts every 16th clock. The count wraps modulo 256.
- R8: In synchronous mode, writing 1 to global-word (address 4) bit 0 with bit 7 clear resets the prescaler, and bit 0 reads back 0 immediately afterwards.
- R9: In asynchronous mode the prescaler-reset bit stays at 1 until the reset has been acknowledged from the timer domain, and then clears by itself.
- R10: While global bit 7 (hold) is 1, the prescaler-reset bit is not cleared and the prescaler stays in reset, so rates 2 and 3 stop counting. After hold is cleared in synchronous mode, the bit clears within two host edges.
- R11: Each time the count steps onto the compare value, `matchIrq` pulses high for exactly one host cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hostClk | input | 1 | Host and synchronous timer clock |
| oscClk | input | 1 | Asynchronous oscillator clock |
| rstN | input | 1 | Active-low asynchronous reset for both domains |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address (0 count, 1 compare, 2 control, 3 status, 4 global) |
| wrData | input | W | Write data |
| rdData | output | W | Read data for `addr` (combinational) |
| matchIrq | output | 1 | One-cycle compare-match pulse in the host domain |
| xtalEn | output | 1 | Crystal oscillator enable |

## Verification
The bench uses the defaults: an 8-bit datapath (W=8) and a 4-bit prescaler (PRE_W=4). With W=8 it can sweep all 256 values through the count, compare and control staging paths. It can also see a full wrap of the counter, and a 768-cycle window holds exactly three matches for any compare value. With PRE_W=4 the rate periods are 4 and 16, so a 64-cycle window gives exact tick counts whatever the prescaler phase. The asynchronous checks run against an oscillator about four times slower than the host clock, which stretches each handshake over several host cycles.

// File: rtl/tbr_pkg.sv
`timescale 1ns/1ps
package tbr_pkg;
  localparam logic [2:0] ADR_CNT  = 3'd0;
  localparam logic [2:0] ADR_CMP  = 3'd1;
  localparam logic [2:0] ADR_CTL  = 3'd2;
  localparam logic [2:0] ADR_STAT = 3'd3;
  localparam logic [2:0] ADR_GLB  = 3'd4;

  // index of each timer register inside the 3-bit strobe and busy vectors
  localparam int IDX_CTL = 0;
  localparam int IDX_CMP = 1;
  localparam int IDX_CNT = 2;

  typedef struct packed {
    logic       asyncSel;  // timer runs from oscillator
    logic [2:0] reqTgl;    // per-register transfer request toggles
    logic [2:0] dirLoad;   // synchronous-mode direct load strobes
    logic       psrLevel;  // prescaler reset request level
    logic       psrNow;    // synchronous one-shot prescaler reset
  } tmrStrobe_t;
endpackage

// File: rtl/tbr_sync.sv
`timescale 1ns/1ps
module tbr_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/tbr_ctrl.sv
`timescale 1ns/1ps
module tbr_ctrl
  import tbr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         hostClk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  input  logic [2:0]   ackTgl,
  input  logic         psrAck,
  input  logic         matchTgl,
  input  logic [W-1:0] liveCount,
  output tmrStrobe_t   strobe,
  output logic [W-1:0] holdCnt,
  output logic [W-1:0] holdCmp,
  output logic [1:0]   holdRate,
  output logic [2:0]   busy,
  output logic         asyncSel,
  output logic         psrBit,
  output logic         psrAckSync,
  output logic         syncHold,
  output logic         matchIrq,
  output logic         xtalEn
);
  logic         extEn;
  logic [W-1:0] holdCtl;
  logic [2:0]   reqTgl;
  logic [2:0]   ackSync;
  logic         matchSync, matchSeen;
  logic [2:0]   wrSel;
  logic         glbWr, psrSet, psrPulse;
  logic [W-1:0] statusWord, globalWord;

  tbr_sync #(.WIDTH(5), .STAGES(2)) uBackSync (
    .clk(hostClk), .rstN(rstN),
    .d({ackTgl, psrAck, matchTgl}),
    .q({ackSync, psrAckSync, matchSync})
  );

  always_comb begin
    wrSel          = '0;
    wrSel[IDX_CNT] = wrEn && (addr == ADR_CNT);
    wrSel[IDX_CMP] = wrEn && (addr == ADR_CMP);
    wrSel[IDX_CTL] = wrEn && (addr == ADR_CTL);
  end

  assign glbWr    = wrEn && (addr == ADR_GLB);
  assign psrSet   = glbWr && wrData[0] && (asyncSel || wrData[7]);
  assign psrPulse = glbWr && wrData[0] && !asyncSel && !wrData[7];

  always_ff @(posedge hostClk or negedge rstN) begin
    if (!rstN) begin
      holdCnt   <= '0;
      holdCmp   <= '0;
      holdCtl   <= '0;
      reqTgl    <= '0;
      extEn     <= 1'b0;
      asyncSel  <= 1'b0;
      syncHold  <= 1'b0;
      psrBit    <= 1'b0;
      matchSeen <= 1'b0;
    end else begin
      if (wrSel[IDX_CNT]) holdCnt <= wrData;
      if (wrSel[IDX_CMP]) holdCmp <= wrData;
      if (wrSel[IDX_CTL]) holdCtl <= wrData;
      reqTgl <= reqTgl ^ (wrSel & {3{asyncSel}});
      if (wrEn && (addr == ADR_STAT)) begin
        extEn    <= wrData[4];
        asyncSel <= wrData[3];
      end
      if (glbWr) syncHold <= wrData[7];
      if (psrSet)
        psrBit <= 1'b1;
      else if (psrBit && !syncHold && (!asyncSel || psrAckSync))
        psrBit <= 1'b0;
      matchSeen <= matchSync;
    end
  end

  assign busy     = reqTgl ^ ackSync;
  assign matchIrq = matchSync ^ matchSeen;
  assign xtalEn   = !extEn;
  assign holdRate = holdCtl[1:0];

  always_comb begin
    strobe          = '0;
    strobe.asyncSel = asyncSel;
    strobe.reqTgl   = reqTgl;
    strobe.dirLoad  = wrSel & {3{!asyncSel}};
    strobe.psrLevel = psrBit;
    strobe.psrNow   = psrPulse;
  end

  always_comb begin
    statusWord      = '0;
    statusWord[4]   = extEn;
    statusWord[3]   = asyncSel;
    statusWord[2:0] = busy;
    globalWord      = '0;
    globalWord[7]   = syncHold;
    globalWord[0]   = psrBit;
    case (addr)
      ADR_CNT:  rdData = liveCount;
      ADR_CMP:  rdData = holdCmp;
      ADR_CTL:  rdData = holdCtl;
      ADR_STAT: rdData = statusWord;
      ADR_GLB:  rdData = globalWord;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/tbr_dp.sv
`timescale 1ns/1ps
module tbr_dp
  import tbr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 4
) (
  input  logic         tmrClk,
  input  logic         rstN,
  input  tmrStrobe_t   strobe,
  input  logic [W-1:0] dirData,
  input  logic [W-1:0] holdCnt,
  input  logic [W-1:0] holdCmp,
  input  logic [1:0]   holdRate,
  output logic [2:0]   ackTgl,
  output logic         psrAck,
  output logic         matchTgl,
  output logic [W-1:0] liveCount
);
  localparam int PRE_STEP = PRE_W / 2;
  localparam logic [PRE_W-1:0] STEP_MASK =
    {{(PRE_W-PRE_STEP){1'b0}}, {PRE_STEP{1'b1}}};

  logic [2:0]       reqSync;
  logic             psrSync;
  logic [2:0]       load;
  logic [W-1:0]     count, cmpVal, srcCnt, srcCmp;
  logic [1:0]       rate, srcRate;
  logic [PRE_W-1:0] preCnt;
  logic             presClr, tick;

  tbr_sync #(.WIDTH(4), .STAGES(2)) uFwdSync (
    .clk(tmrClk), .rstN(rstN),
    .d({strobe.reqTgl, strobe.psrLevel}),
    .q({reqSync, psrSync})
  );

  assign load    = strobe.dirLoad | (reqSync ^ ackTgl);
  assign srcCnt  = strobe.asyncSel ? holdCnt  : dirData;
  assign srcCmp  = strobe.asyncSel ? holdCmp  : dirData;
  assign srcRate = strobe.asyncSel ? holdRate : dirData[1:0];
  assign presClr = strobe.psrNow | (strobe.asyncSel ? psrSync : strobe.psrLevel);
  assign psrAck  = psrSync;

  always_comb begin
    case (rate)
      2'd0:    tick = 1'b0;
      2'd1:    tick = 1'b1;
      2'd2:    tick = (preCnt & STEP_MASK) == STEP_MASK;
      default: tick = &preCnt;
    endcase
  end

  always_ff @(posedge tmrClk or negedge rstN) begin
    if (!rstN) begin
      ackTgl   <= '0;
      count    <= '0;
      cmpVal   <= '0;
      rate     <= '0;
      preCnt   <= '0;
      matchTgl <= 1'b0;
    end else begin
      ackTgl <= reqSync;
      preCnt <= presClr ? '0 : preCnt + 1'b1;
      if (load[IDX_CMP]) cmpVal <= srcCmp;
      if (load[IDX_CTL]) rate   <= srcRate;
      if (load[IDX_CNT]) begin
        count <= srcCnt;
      end else if (tick) begin
        count <= count + W'(1);
        if (count + W'(1) == cmpVal) matchTgl <= ~matchTgl;
      end
    end
  end

  assign liveCount = count;
endmodule

// File: rtl/async_timer_bridge.sv
`timescale 1ns/1ps
module async_timer_bridge
  import tbr_pkg::*;
#(
  parameter int W     = 8,
  parameter int PRE_W = 4
) (
  input  logic         hostClk,
  input  logic         oscClk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         matchIrq,
  output logic         xtalEn
);
  tmrStrobe_t   strobe;
  logic [W-1:0] holdCnt, holdCmp, liveCount;
  logic [1:0]   holdRate;
  logic [2:0]   ackTgl, busy;
  logic         psrAck, matchTgl, asyncSel, psrBit, psrAckSync, syncHold;
  logic         tmrClk;

  assign tmrClk = asyncSel ? oscClk : hostClk;

  tbr_ctrl #(.W(W)) uCtrl (
    .hostClk(hostClk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .ackTgl(ackTgl), .psrAck(psrAck),
    .matchTgl(matchTgl), .liveCount(liveCount), .strobe(strobe),
    .holdCnt(holdCnt), .holdCmp(holdCmp), .holdRate(holdRate),
    .busy(busy), .asyncSel(asyncSel), .psrBit(psrBit),
    .psrAckSync(psrAckSync), .syncHold(syncHold),
    .matchIrq(matchIrq), .xtalEn(xtalEn)
  );

  tbr_dp #(.W(W), .PRE_W(PRE_W)) uDp (
    .tmrClk(tmrClk), .rstN(rstN), .strobe(strobe), .dirData(wrData),
    .holdCnt(holdCnt), .holdCmp(holdCmp), .holdRate(holdRate),
    .ackTgl(ackTgl), .psrAck(psrAck), .matchTgl(matchTgl),
    .liveCount(liveCount)
  );
endmodule

// File: rtl/tbr_chk.sv
`timescale 1ns/1ps
module tbr_chk #(
  parameter int W = 8
) (
  input logic         hostClk,
  input logic         rstN,
  input logic         wrEn,
  input logic [2:0]   addr,
  input logic [W-1:0] wrData,
  input logic [W-1:0] liveCount,
  input logic [2:0]   busy,
  input logic         asyncSel,
  input logic         psrBit,
  input logic         psrAckSync,
  input logic         syncHold,
  input logic         matchIrq
);
  // R2
  sync_nobusy_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    !asyncSel |-> (busy == 3'b000));

  // R2
  direct_load_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    (wrEn && addr == 3'd0 && !asyncSel) |=> (liveCount == $past(wrData)));

  // R3
  busy_set_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    (wrEn && addr == 3'd1 && asyncSel && !busy[1]) |=> busy[1]);

  // R9
  psr_wait_ack_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    (psrBit && asyncSel && !psrAckSync) |=> psrBit);

  // R10
  psr_hold_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    (psrBit && syncHold) |=> psrBit);

  // R11
  irq_single_chk: assert property (@(posedge hostClk) disable iff (!rstN)
    matchIrq |=> !matchIrq);
endmodule

bind async_timer_bridge tbr_chk #(.W(W)) uChk (
  .hostClk(hostClk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
  .wrData(wrData), .liveCount(liveCount), .busy(busy),
  .asyncSel(asyncSel), .psrBit(psrBit), .psrAckSync(psrAckSync),
  .syncHold(syncHold), .matchIrq(matchIrq)
);

// File: tb/test_async_timer_bridge.sv
`timescale 1ns/1ps
module test_async_timer_bridge;
  logic       hostClk = 1'b0;
  logic       oscClk  = 1'b0;
  logic       rstN    = 1'b0;
  logic       wrEn    = 1'b0;
  logic [2:0] addr    = '0;
  logic [7:0] wrData  = '0;
  logic [7:0] rdData;
  logic       matchIrq, xtalEn;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  async_timer_bridge i_async_timer_bridge (
    .hostClk(hostClk), .oscClk(oscClk), .rstN(rstN), .wrEn(wrEn),
    .addr(addr), .wrData(wrData), .rdData(rdData),
    .matchIrq(matchIrq), .xtalEn(xtalEn)
  );

  always #4 hostClk = ~hostClk;
  initial begin
    #3;
    forever #15 oscClk = ~oscClk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge hostClk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge hostClk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitIdle(output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      rd(3'd3, s);
      if (s[2:0] == 3'b000) begin ok = 1; break; end
      @(negedge hostClk);
    end
  endtask

  task automatic countIrq(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge hostClk);
      #1;
      if (matchIrq) n++;
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

  initial begin
    logic [7:0] v, a, b;
    bit ok;
    int n;
    repeat (5) @(negedge hostClk);
    rstN = 1'b1;
    @(negedge hostClk);

    // R1 reset state
    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v);
      chk("R1 word", v, 0);
    end
    chk("R1 xtalEn", xtalEn, 1);

    // R6 status layout, busy bits read-only
    wr(3'd3, 8'h07); rd(3'd3, v); chk("R6 busy ro", v, 0);
    wr(3'd3, 8'h10); rd(3'd3, v); chk("R6 ext", v, 8'h10);
    chk("R6 xtalEn", xtalEn, 0);
    wr(3'd3, 8'h00); chk("R6 xtalEn back", xtalEn, 1);

    // R2/R5 sync sweep over all values
    for (int k = 0; k < 256; k++) begin
      wr(3'd0, 8'(k)); rd(3'd0, v); chk("R2 count", v, k);
      wr(3'd1, 8'(k)); rd(3'd1, v); chk("R5 compare", v, k);
      wr(3'd2, 8'(k & 8'hFC)); rd(3'd2, v); chk("R5 control", v, k & 8'hFC);
    end
    rd(3'd3, v); chk("R2 no busy", v, 0);

    // R7 rate 1 and wrap
    wr(3'd2, 8'h01);
    wr(3'd0, 8'h00);
    rd(3'd0, v); chk("R7 start", v, 0);
    repeat (300) @(negedge hostClk);
    rd(3'd0, v); chk("R7 wrap", v, 300 % 256);
    // R7 rate 2, 3, 0 over 64-cycle windows
    wr(3'd2, 8'h02); repeat (3) @(negedge hostClk);
    rd(3'd0, a); repeat (64) @(negedge hostClk); rd(3'd0, b);
    chk("R7 rate2", 8'(b - a), 16);
    wr(3'd2, 8'h03); repeat (3) @(negedge hostClk);
    rd(3'd0, a); repeat (64) @(negedge hostClk); rd(3'd0, b);
    chk("R7 rate3", 8'(b - a), 4);
    wr(3'd2, 8'h00);
    rd(3'd0, a); repeat (64) @(negedge hostClk); rd(3'd0, b);
    chk("R7 stopped", 8'(b - a), 0);

    // R8 sync self-clear
    wr(3'd4, 8'h01); rd(3'd4, v); chk("R8 self clear", v, 0);

    // R10 hold in sync mode
    wr(3'd2, 8'h02);
    wr(3'd4, 8'h81); rd(3'd4, v); chk("R10 held", v, 8'h81);
    rd(3'd0, a); repeat (64) @(negedge hostClk); rd(3'd0, b);
    chk("R10 frozen", 8'(b - a), 0);
    wr(3'd4, 8'h00); @(negedge hostClk);
    rd(3'd4, v); chk("R10 release", v, 0);
    repeat (3) @(negedge hostClk);
    rd(3'd0, a); repeat (64) @(negedge hostClk); rd(3'd0, b);
    chk("R10 resumed", 8'(b - a), 16);

    // R11 sync match, several compare values
    wr(3'd2, 8'h01);
    foreach (v[i]) begin end
    for (int c = 0; c < 4; c++) begin
      wr(3'd1, (c == 0) ? 8'd0 : (c == 1) ? 8'd1 : (c == 2) ? 8'd127 : 8'd255);
      repeat (10) @(negedge hostClk);
      countIrq(768, n);
      chk("R11 sync matches", n, 3);
    end

    // async mode
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h18); rd(3'd3, v); chk("R6 async status", v, 8'h18);

    // R3/R4/R5 compare
    wr(3'd1, 8'h5A);
    rd(3'd3, v); chk("R3 cmp busy", v[2:0], 3'b010);
    rd(3'd1, v); chk("R5 staged cmp", v, 8'h5A);
    waitIdle(ok); chk("R4 cmp idle", ok, 1);

    // R3/R4 count
    wr(3'd0, 8'h33);
    rd(3'd3, v); chk("R3 cnt busy", v[2:0], 3'b100);
    waitIdle(ok); chk("R4 cnt idle", ok, 1);
    rd(3'd0, v); chk("R4 cnt value", v, 8'h33);

    // R3/R4 control
    wr(3'd2, 8'h01);
    rd(3'd3, v); chk("R3 ctl busy", v[2:0], 3'b001);
    waitIdle(ok); chk("R4 ctl idle", ok, 1);
    rd(3'd0, a); repeat (200) @(negedge hostClk); rd(3'd0, b);
    chk("R4 ctl running", (a != b) ? 1 : 0, 1);
    wr(3'd2, 8'h00); waitIdle(ok); chk("R4 ctl stop idle", ok, 1);

    // R9 async prescaler reset waits for acknowledge
    wr(3'd4, 8'h01);
    rd(3'd4, v); chk("R9 pending", v, 1);
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      rd(3'd4, v);
      if (v[0] == 1'b0) begin ok = 1; break; end
      @(negedge hostClk);
    end
    chk("R9 cleared", ok, 1);

    // R10 async hold
    wr(3'd4, 8'h81); repeat (50) @(negedge hostClk);
    rd(3'd4, v); chk("R10 async held", v, 8'h81);
    wr(3'd4, 8'h00);
    ok = 0;
    for (int i = 0; i < 100; i++) begin
      rd(3'd4, v);
      if (v == 8'h00) begin ok = 1; break; end
      @(negedge hostClk);
    end
    chk("R10 async release", ok, 1);

    // R11 async match
    wr(3'd1, 8'h05); waitIdle(ok);
    wr(3'd2, 8'h01); waitIdle(ok);
    countIrq(2000, n);
    chk("R11 async matches", (n >= 1 && n <= 3) ? 1 : 0, 1);

    done = 1;
    summary();
  end
endmodule